// File: doc/BRIEF.md
# Least-Used Category Recode Selector

This block sits beside the weight array of a category classifier and decides which category row should receive a fresh copy of the current input when no stored category meets the vigilance test. Each row keeps a leaky activity score. The score rises by a fixed step each time that row wins a presentation and loses a fraction of its value on every decay tick. Rows that win rarely therefore drift toward zero.

When the classifier reports that nothing matched, the block first looks for a row that has never been coded. If one exists, the lowest-numbered free row is granted. If every row is already in use and replacement is allowed, a parallel minimum search over all activity scores picks the least-used row. If replacement is not allowed, no row is granted. The grant is a one-cycle, registered one-hot pulse. The weight logic uses this pulse to apply its copy-rate learning to that row. At the same edge the granted row's score is set to mid-scale, so the row is not sacrificed again straight away.

The control path is a two-state machine. `ST_IDLE` waits for a no-match. The `IDLE_TO_ISSUE` transition fires when a no-match arrives and a row can be selected. `ST_ISSUE` drives the grant for one cycle. It then takes `ISSUE_TO_IDLE` when the no-match input is low, or `ISSUE_TO_ISSUE` when another selectable no-match arrives straight away.

Top module: `catrec_top`

## Requirements
- R1: After reset every activity score is 0, `recode_valid` is 0 and `recode_row` is all zeros.
- R2: A cycle with `win_onehot[r]` high adds 16 to row r's score. The score saturates at 255 and never wraps.
- R3: A cycle with `decay_tick` high replaces the score a of every row that neither wins nor is granted with a - (a >> 4). When a row wins in the same cycle, the win takes precedence and the decay is skipped for that row.
- R4: When `no_match` is high and `unused_mask` has any bit set, the grant in the next cycle is the lowest-indexed row whose `unused_mask` bit is 1 (bit r stands for row r). This happens whatever the value of `recode_en`.
- R5: When `no_match` is high, `unused_mask` is all zeros and `recode_en` is 1, the grant is the row with the smallest score. Ties go to the lowest index.
- R6: When `no_match` is high, `unused_mask` is all zeros and `recode_en` is 0, no grant is issued and no score is changed by the no-match.
- R7: The granted row's score is set to 128 at the same edge that registers the grant. This load overrides a win or a decay on that row in the same cycle.
- R8: `recode_valid` is high exactly in the cycle after each cycle with a selectable no-match. Back-to-back no-match cycles give back-to-back grants.
- R9: `recode_row` is one-hot while `recode_valid` is high and all zeros otherwise. Bit r of `recode_row` stands for row r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_onehot | input | N_ROWS | Winning category of this presentation (at most one bit high) |
| decay_tick | input | 1 | Apply one leak step to the activity scores |
| no_match | input | 1 | No category met vigilance in this presentation |
| recode_en | input | 1 | Allow replacement of in-use rows |
| unused_mask | input | N_ROWS | Rows never coded yet, bit r stands for row r |
| recode_row | output | N_ROWS | One-hot row chosen for copy-rate learning |
| recode_valid | output | 1 | Grant pulse, one cycle per selectable no-match |

## Verification
The assertions check several properties on every cycle. They check that a grant only follows a no-match, that the grant is one-hot or empty, and that a free row always wins over an in-use row. They check that an in-use row is granted only when replacement was enabled. They also check that a win never lowers a score and that a decay never raises one. Only the bench scenarios can show which row the minimum search actually picks. The same holds for tie order, the exact step and leak amounts, saturation at full scale, and the mid-scale reload after a grant. All of these are visible only through the sequence of rows granted over many presentations.

// File: rtl/catrec_pkg.sv
package catrec_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } issue_state_e;

endpackage

// File: rtl/catrec_activity.sv
module catrec_activity #(
    parameter int ACT_W  = 8,
    parameter int STEP   = 16,
    parameter int SHIFT  = 4,
    parameter int MID    = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             decay,
    input  logic             load,
    output logic [ACT_W-1:0] act
);

    localparam logic [ACT_W:0]   STEP_EXT = (ACT_W+1)'(STEP);
    localparam logic [ACT_W-1:0] ACT_MAX  = {ACT_W{1'b1}};
    localparam logic [ACT_W-1:0] ACT_MID  = ACT_W'(MID);

    logic [ACT_W:0]   sum_ext;
    logic [ACT_W-1:0] inc_val;
    logic [ACT_W-1:0] leak_val;
    logic [ACT_W-1:0] act_next;

    // R2: saturating increment
    always_comb begin
        sum_ext = {1'b0, act} + STEP_EXT;
        inc_val = sum_ext[ACT_W] ? ACT_MAX : sum_ext[ACT_W-1:0];
    end

    // R3: proportional leak
    always_comb begin
        leak_val = act - (act >> SHIFT);
    end

    // R7 load beats R2 win beats R3 decay
    always_comb begin
        if (load) begin
            act_next = ACT_MID;
        end else if (inc) begin
            act_next = inc_val;
        end else if (decay) begin
            act_next = leak_val;
        end else begin
            act_next = act;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act <= '0;
        end else begin
            act <= act_next;
        end
    end

    assert_win_no_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (act >= $past(act)));

    assert_decay_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (decay && !inc && !load) |=> (act <= $past(act)));

endmodule

// File: rtl/catrec_first.sv
module catrec_first #(
    parameter int N_ROWS = 8
) (
    input  logic [N_ROWS-1:0] mask,
    output logic [N_ROWS-1:0] first_oh,
    output logic              any_set
);

    always_comb begin
        first_oh = '0;
        for (int i = N_ROWS - 1; i >= 0; i--) begin
            if (mask[i]) begin
                first_oh = '0;
                first_oh[i] = 1'b1;
            end
        end
        any_set = |mask;
    end

endmodule

// File: rtl/catrec_minsel.sv
module catrec_minsel #(
    parameter int N_ROWS = 8,
    parameter int ACT_W  = 8
) (
    input  logic [N_ROWS*ACT_W-1:0] act_flat,
    output logic [N_ROWS-1:0]       min_oh
);

    localparam int IDX_W = (N_ROWS > 1) ? $clog2(N_ROWS) : 1;

    logic [ACT_W-1:0] best_val;
    logic [IDX_W-1:0] best_idx;

    // R5: strict less-than keeps the lowest index on ties
    always_comb begin
        best_val = act_flat[ACT_W-1:0];
        best_idx = '0;
        for (int i = 1; i < N_ROWS; i++) begin
            if (act_flat[i*ACT_W +: ACT_W] < best_val) begin
                best_val = act_flat[i*ACT_W +: ACT_W];
                best_idx = IDX_W'(i);
            end
        end
        min_oh = '0;
        min_oh[best_idx] = 1'b1;
    end

endmodule

// File: rtl/catrec_top.sv
module catrec_top
    import catrec_pkg::*;
#(
    parameter int N_ROWS = 8,
    parameter int ACT_W  = 8,
    parameter int STEP   = 16,
    parameter int SHIFT  = 4,
    parameter int MID    = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_ROWS-1:0] win_onehot,
    input  logic              decay_tick,
    input  logic              no_match,
    input  logic              recode_en,
    input  logic [N_ROWS-1:0] unused_mask,
    output logic [N_ROWS-1:0] recode_row,
    output logic              recode_valid
);

    issue_state_e state_q, state_d;

    logic [N_ROWS*ACT_W-1:0] act_flat;
    logic [N_ROWS-1:0]       free_oh;
    logic                    free_any;
    logic [N_ROWS-1:0]       min_oh;
    logic [N_ROWS-1:0]       sel_oh;
    logic                    sel_found;
    logic                    take;
    logic [N_ROWS-1:0]       load_vec;
    logic [N_ROWS-1:0]       row_q;

    genvar g;
    generate
        for (g = 0; g < N_ROWS; g++) begin : g_row
            catrec_activity #(
                .ACT_W (ACT_W),
                .STEP  (STEP),
                .SHIFT (SHIFT),
                .MID   (MID)
            ) act_i (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (win_onehot[g]),
                .decay (decay_tick),
                .load  (load_vec[g]),
                .act   (act_flat[g*ACT_W +: ACT_W])
            );
        end
    endgenerate

    catrec_first #(.N_ROWS(N_ROWS)) first_i (
        .mask     (unused_mask),
        .first_oh (free_oh),
        .any_set  (free_any)
    );

    catrec_minsel #(.N_ROWS(N_ROWS), .ACT_W(ACT_W)) minsel_i (
        .act_flat (act_flat),
        .min_oh   (min_oh)
    );

    // R4 free row first, R5 least-used when allowed, R6 nothing otherwise
    always_comb begin
        sel_found = free_any | recode_en;
        if (free_any) begin
            sel_oh = free_oh;
        end else if (recode_en) begin
            sel_oh = min_oh;
        end else begin
            sel_oh = '0;
        end
        take     = no_match && sel_found;
        load_vec = take ? sel_oh : '0;
    end

    // next-state logic: IDLE_TO_ISSUE, ISSUE_TO_ISSUE, ISSUE_TO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = take ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = take ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register (R1, R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else begin
            row_q <= take ? sel_oh : '0;
        end
    end

    assign recode_row   = row_q;
    assign recode_valid = (state_q == ST_ISSUE);

    assert_grant_after_nomatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        recode_valid |-> $past(no_match));

    assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        recode_valid |-> ($countones(recode_row) == 1));

    assert_idle_row_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !recode_valid |-> (recode_row == '0));

    assert_free_row_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (recode_valid && $past(|unused_mask)) |-> ((recode_row & $past(unused_mask)) != '0));

    assert_replace_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (recode_valid && !$past(|unused_mask)) |-> $past(recode_en));

endmodule

// File: tb/catrec_top_tb_top.sv
module catrec_top_tb_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] win_onehot = '0;
    logic         decay_tick = 1'b0;
    logic         no_match = 1'b0;
    logic         recode_en = 1'b0;
    logic [N-1:0] unused_mask = '0;
    logic [N-1:0] recode_row;
    logic         recode_valid;

    int checks = 0;
    int errors = 0;
    int act_m [N];

    always #10ns clk = ~clk;

    catrec_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .win_onehot   (win_onehot),
        .decay_tick   (decay_tick),
        .no_match     (no_match),
        .recode_en    (recode_en),
        .unused_mask  (unused_mask),
        .recode_row   (recode_row),
        .recode_valid (recode_valid)
    );

    task automatic check(input string tag, input logic [N-1:0] row_e, input logic v_e);
        checks++;
        if (recode_valid !== v_e || recode_row !== row_e) begin
            errors++;
            $display("FAIL %s: valid=%b row=%b expected valid=%b row=%b",
                     tag, recode_valid, recode_row, v_e, row_e);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        win_onehot = '0; decay_tick = 0; no_match = 0; recode_en = 0; unused_mask = '0;
        for (int i = 0; i < N; i++) act_m[i] = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset outputs", '0, 1'b0);
    endtask

    // one presentation cycle: drive, predict, clock, check
    task automatic step(input logic [N-1:0] w, input logic d, input logic nm,
                        input logic en, input logic [N-1:0] um, input string tag);
        logic [N-1:0] sel;
        logic         found;
        int           best;
        win_onehot = w; decay_tick = d; no_match = nm; recode_en = en; unused_mask = um;
        sel = '0;
        found = 1'b0;
        if (um != '0) begin
            for (int i = N - 1; i >= 0; i--) if (um[i]) begin sel = '0; sel[i] = 1'b1; end
            found = 1'b1;
        end else if (en) begin
            best = 0;
            for (int i = 1; i < N; i++) if (act_m[i] < act_m[best]) best = i;
            sel[best] = 1'b1;
            found = 1'b1;
        end
        found = found && nm;
        for (int i = 0; i < N; i++) begin
            if (found && sel[i]) act_m[i] = 128;
            else if (w[i]) act_m[i] = (act_m[i] + 16 > 255) ? 255 : act_m[i] + 16;
            else if (d) act_m[i] = act_m[i] - (act_m[i] >> 4);
        end
        @(posedge clk);
        @(negedge clk);
        win_onehot = '0; decay_tick = 0; no_match = 0; unused_mask = '0;
        check(tag, found ? sel : '0, found);
    endtask

    task automatic wins(input int row, input int count);
        for (int k = 0; k < count; k++) step(N'(1) << row, 1'b0, 1'b0, 1'b1, '0, "R2 win step");
    endtask

    task automatic t_free_first();
        do_reset();
        step('0, 0, 1, 0, 8'b0010_1100, "R4 free row with replace off");
        step('0, 0, 1, 1, 8'b1000_0000, "R4 free row top index");
        step('0, 0, 0, 1, '0, "R8 no grant without no_match");
    endtask

    task automatic t_tie_and_min();
        do_reset();
        step('0, 0, 1, 1, '0, "R1 zero scores tie to row0");
        do_reset();
        wins(0, 1);
        step('0, 0, 1, 1, '0, "R5 tie lowest among zeros");
        do_reset();
        for (int r = 0; r < N; r++) wins(r, (r == 5) ? 1 : 3);
        step('0, 0, 1, 1, '0, "R5 unique minimum row5");
    endtask

    task automatic t_saturate();
        do_reset();
        for (int r = 0; r < N; r++) wins(r, (r == 1) ? 17 : 5);
        step('0, 0, 1, 1, '0, "R2 saturated row not chosen");
    endtask

    task automatic t_decay();
        do_reset();
        for (int r = 0; r < N; r++) wins(r, (r == 0) ? 8 : 9);
        step(8'b0000_0001, 1, 0, 1, '0, "R3 decay with win on row0");
        step('0, 0, 1, 1, '0, "R3 decayed row1 is minimum");
    endtask

    task automatic t_disabled();
        do_reset();
        wins(2, 1);
        step('0, 0, 1, 0, '0, "R6 no grant when replace off");
        step('0, 0, 1, 1, '0, "R6 scores untouched then row0");
    endtask

    task automatic t_mid_load();
        do_reset();
        step(8'b0000_0001, 0, 1, 1, '0, "R7 load overrides win");
        for (int k = 1; k < N; k++) step('0, 0, 1, 1, '0, "R8 back-to-back grant");
        step('0, 0, 1, 1, '0, "R7 all mid-scale tie row0");
        step('0, 0, 0, 1, '0, "R9 grant drops after burst");
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_free_first();
        t_tie_and_min();
        t_saturate();
        t_decay();
        t_disabled();
        t_mid_load();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule